// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh Controller

This block keeps the dynamic cells of a byte-wide memory alive behind an interface that looks like a static RAM: chip enable, a shared output-enable/refresh pin and a flat address. It watches those pins and issues one-cycle row-refresh requests to a behavioural storage array beside it. The array has 256 rows. The row index is the upper 8 bits of the 15-bit word address; the lower 7 bits pick a byte inside the row and are not routed to this block.

Three refresh sources feed the requests. Any chip-enable cycle refreshes its addressed row: a read, a write, or a cycle with no data transfer at all. A pulse on the refresh pin while the chip is deselected refreshes the row that an internal counter points to. If the refresh pin is held low for long enough while the chip is deselected, an internal timer takes over and walks the counter at a rate that covers every row before the deadline. A bank of per-row age counters, measured in clock cycles, raises a sticky error if any row goes unrefreshed past the deadline.

Top module: `psram_refresh_ctrl`

## Requirements
- R1: `row_addr` carries the row index (address bits 14:7). Every value from 0 to 2**ROW_W-1 is a legal row, and the reported `rfsh_row` equals the value sampled.
- R2: A chip-enable cycle (`ce_n` low, then high) produces exactly one `rfsh_valid` pulse of one cycle after `ce_n` returns high. `rfsh_row` equals the row present at the first clock edge that saw `ce_n` low, and later changes of `row_addr` inside the cycle are ignored.
- R3: A falling edge of `oe_rf_n` while `ce_n` is low is part of an access and does not advance the refresh counter. The cycle refreshes only its addressed row.
- R4: Each falling edge of `oe_rf_n` with `ce_n` high produces one refresh of the counter row. The counter is 0 after reset, rises by one per counter refresh and wraps from 255 to 0.
- R5: When `oe_rf_n` is low and `ce_n` is high at more than SELF_THRESH consecutive sampled edges, `self_active` goes to 1. While it is 1, one counter row is refreshed every SELF_PERIOD cycles, with SELF_PERIOD = (DEADLINE_CYC - SELF_THRESH - 8) / 256, so that all rows are covered within the deadline.
- R6: `self_active` returns to 0 one cycle after `ce_n` is sampled low or `oe_rf_n` is sampled high.
- R7: A counter request raised while `ce_n` is low is held with no refresh issued. It is serviced after the access ends: the access row is issued first, and the counter row follows in the next cycle.
- R8: `deadline_err` becomes 1 when any row has gone more than DEADLINE_CYC cycles without a refresh. It then stays 1 until reset, whatever refreshes follow.
- R9: During and after reset `rfsh_valid`, `self_active` and `deadline_err` are 0. Reset is asynchronous active-low and is released synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_rf_n | input | 1 | Output enable / refresh clock, active low |
| row_addr | input | ROW_W | Row part of the word address (bits 14:7) |
| rfsh_valid | output | 1 | One-cycle row-refresh request to the storage array |
| rfsh_row | output | ROW_W | Row to refresh when `rfsh_valid` is 1 |
| self_active | output | 1 | Timer-driven self refresh is running |
| deadline_err | output | 1 | Sticky flag: some row exceeded its refresh deadline |

## Verification
The main function is exercised with chip-enable cycles on the extreme and middle row values, mixed in with refresh-pin pulses. This separates the addressed-row path from the counter path, and a long train of pulses confirms the 255-to-0 wrap. Refresh-pin pulses inside an access show that the counter ignores them. A pulse followed at once by an access shows that the held request comes out after the access row, in order. A long hold of the refresh pin checks the exact entry cycle of self refresh, the consecutive row walk and full coverage with no error. An idle stretch then shows that the error appears only after the deadline and stays set.

// File: rtl/psr_pkg.sv
package psr_pkg;

  // Source that wins the refresh output in a given cycle.
  typedef enum logic [1:0] {
    RF_IDLE    = 2'd0,
    RF_ACCESS  = 2'd1,
    RF_COUNTER = 2'd2
  } rf_src_e;

endpackage

// File: rtl/psr_pin_sync.sv
module psr_pin_sync #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_rf_n,
  input  logic [ROW_W-1:0] row_addr,
  output logic             ce_act,
  output logic             oe_act,
  output logic [ROW_W-1:0] row_q,
  output logic             ce_start,
  output logic             ce_end,
  output logic             oe_fall
);

  logic ce_act_q, ce_act_p, oe_act_q, oe_act_p;
  logic ce_act_d, oe_act_d;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    ce_act_d = ~ce_n;
    oe_act_d = ~oe_rf_n;
    row_d    = row_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_act_q <= 1'b0;
      ce_act_p <= 1'b0;
      oe_act_q <= 1'b0;
      oe_act_p <= 1'b0;
      row_q    <= '0;
    end else begin
      ce_act_q <= ce_act_d;
      ce_act_p <= ce_act_q;
      oe_act_q <= oe_act_d;
      oe_act_p <= oe_act_q;
      row_q    <= row_d;
    end
  end

  assign ce_act   = ce_act_q;
  assign oe_act   = oe_act_q;
  assign ce_start = ce_act_q & ~ce_act_p;
  assign ce_end   = ~ce_act_q & ce_act_p;
  assign oe_fall  = oe_act_q & ~oe_act_p;

endmodule

// File: rtl/psr_self_timer.sv
module psr_self_timer #(
  parameter int SELF_THRESH = 64,
  parameter int SELF_PERIOD = 3905
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_act,
  input  logic oe_act,
  output logic self_active,
  output logic self_tick
);

  localparam int HOLD_W = $clog2(SELF_THRESH + 2);
  localparam int PER_W  = $clog2(SELF_PERIOD + 1);

  logic              idle_hold;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic [PER_W-1:0]  per_q, per_d;
  logic              self_q, self_d;
  logic              per_last;

  assign idle_hold = oe_act & ~ce_act;
  assign per_last  = (per_q == PER_W'(SELF_PERIOD - 1));

  always_comb begin
    hold_d = '0;
    if (idle_hold) begin
      if (hold_q == HOLD_W'(SELF_THRESH)) hold_d = hold_q;
      else                                hold_d = hold_q + 1'b1;
    end
    self_d = idle_hold & (hold_q >= HOLD_W'(SELF_THRESH));
    per_d  = '0;
    if (self_q && idle_hold && !per_last) per_d = per_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      per_q  <= '0;
      self_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      per_q  <= per_d;
      self_q <= self_d;
    end
  end

  assign self_active = self_q;
  assign self_tick   = self_q & idle_hold & per_last;

  assert_self_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    self_q |-> $past(oe_act && !ce_act));

endmodule

// File: rtl/psr_row_arbiter.sv
module psr_row_arbiter
  import psr_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_act,
  input  logic             ce_start,
  input  logic             ce_end,
  input  logic             oe_fall,
  input  logic [ROW_W-1:0] row_q,
  input  logic             self_tick,
  output logic             rfsh_valid,
  output logic [ROW_W-1:0] rfsh_row
);

  logic [ROW_W-1:0] lat_q, lat_d;
  logic [ROW_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             vld_q, vld_d;
  logic [ROW_W-1:0] out_q, out_d;
  logic             auto_evt, grant;
  rf_src_e          src;

  assign auto_evt = oe_fall & ~ce_act;
  assign grant    = pend_q & ~ce_act & ~ce_end;

  always_comb begin
    if (ce_end)     src = RF_ACCESS;
    else if (grant) src = RF_COUNTER;
    else            src = RF_IDLE;
  end

  always_comb begin
    lat_d  = ce_start ? row_q : lat_q;
    cnt_d  = grant ? cnt_q + 1'b1 : cnt_q;
    pend_d = (pend_q & ~grant) | auto_evt | self_tick;
    vld_d  = (src != RF_IDLE);
    unique case (src)
      RF_ACCESS:  out_d = lat_q;
      RF_COUNTER: out_d = cnt_q;
      default:    out_d = out_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      out_q  <= '0;
    end else begin
      lat_q  <= lat_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      vld_q  <= vld_d;
      out_q  <= out_d;
    end
  end

  assign rfsh_valid = vld_q;
  assign rfsh_row   = out_q;

  assert_access_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ce_end |=> (rfsh_valid && rfsh_row == $past(lat_q)));

  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ce_act |=> !rfsh_valid);

endmodule

// File: rtl/psr_age_tracker.sv
module psr_age_tracker #(
  parameter int ROW_W        = 8,
  parameter int DEADLINE_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_valid,
  input  logic [ROW_W-1:0] rf_row,
  output logic             deadline_err
);

  localparam int ROWS  = 1 << ROW_W;
  localparam int AGE_W = $clog2(DEADLINE_CYC + 2);

  logic [ROWS-1:0] late;
  logic            err_q, err_d;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic [AGE_W-1:0] age_q, age_d;
    always_comb begin
      age_d = age_q;
      if (rf_valid && rf_row == ROW_W'(i))   age_d = '0;
      else if (age_q <= AGE_W'(DEADLINE_CYC)) age_d = age_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age_q <= '0;
      else        age_q <= age_d;
    end
    assign late[i] = (age_q > AGE_W'(DEADLINE_CYC));
  end

  always_comb err_d = err_q | (|late);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign deadline_err = err_q;

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deadline_err |=> deadline_err);

endmodule

// File: rtl/psram_refresh_ctrl.sv
module psram_refresh_ctrl #(
  parameter int ROW_W        = 8,
  parameter int DEADLINE_CYC = 1000000,
  parameter int SELF_THRESH  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_rf_n,
  input  logic [ROW_W-1:0] row_addr,
  output logic             rfsh_valid,
  output logic [ROW_W-1:0] rfsh_row,
  output logic             self_active,
  output logic             deadline_err
);

  localparam int ROWS        = 1 << ROW_W;
  localparam int SELF_PERIOD = (DEADLINE_CYC - SELF_THRESH - 8) / ROWS;

  logic rst_m, rst_s;
  logic ce_act, oe_act, ce_start, ce_end, oe_fall, self_tick;
  logic [ROW_W-1:0] row_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  psr_pin_sync #(.ROW_W(ROW_W)) u_pins (
    .clk(clk), .rst_n(rst_s), .ce_n(ce_n), .oe_rf_n(oe_rf_n),
    .row_addr(row_addr), .ce_act(ce_act), .oe_act(oe_act), .row_q(row_q),
    .ce_start(ce_start), .ce_end(ce_end), .oe_fall(oe_fall)
  );

  psr_self_timer #(.SELF_THRESH(SELF_THRESH), .SELF_PERIOD(SELF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_s), .ce_act(ce_act), .oe_act(oe_act),
    .self_active(self_active), .self_tick(self_tick)
  );

  psr_row_arbiter #(.ROW_W(ROW_W)) u_arb (
    .clk(clk), .rst_n(rst_s), .ce_act(ce_act), .ce_start(ce_start),
    .ce_end(ce_end), .oe_fall(oe_fall), .row_q(row_q), .self_tick(self_tick),
    .rfsh_valid(rfsh_valid), .rfsh_row(rfsh_row)
  );

  psr_age_tracker #(.ROW_W(ROW_W), .DEADLINE_CYC(DEADLINE_CYC)) u_age (
    .clk(clk), .rst_n(rst_s), .rf_valid(rfsh_valid), .rf_row(rfsh_row),
    .deadline_err(deadline_err)
  );

  assert_tick_in_self_R5: assert property (@(posedge clk) disable iff (!rst_s)
    self_tick |-> self_active);

endmodule

// File: tb/tb_psram_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_psram_refresh_ctrl;

  localparam int ROW_W    = 8;
  localparam int DEADLINE = 2560;
  localparam int THRESH   = 8;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_rf_n;
  logic [ROW_W-1:0] row_addr;
  logic rfsh_valid, self_active, deadline_err;
  logic [ROW_W-1:0] rfsh_row;

  always #2 clk = ~clk;

  psram_refresh_ctrl #(.ROW_W(ROW_W), .DEADLINE_CYC(DEADLINE), .SELF_THRESH(THRESH)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_rf_n(oe_rf_n), .row_addr(row_addr),
    .rfsh_valid(rfsh_valid), .rfsh_row(rfsh_row), .self_active(self_active),
    .deadline_err(deadline_err)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Refresh event log, sampled on the falling edge.
  int ev_n = 0, cyc = 0;
  logic [ROW_W-1:0] ev_row [8192];
  int ev_cyc [8192];
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && rfsh_valid && ev_n < 8192) begin
      ev_row[ev_n] <= rfsh_row;
      ev_cyc[ev_n] <= cyc;
      ev_n <= ev_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b1; oe_rf_n = 1'b1; row_addr = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
  endtask

  // Chip-enable cycle; the address is disturbed after the first sampled edge.
  task automatic ce_cycle(input logic [ROW_W-1:0] r);
    ce_n = 1'b0; row_addr = r;
    wait_n(1);
    row_addr = ~r;
    wait_n(2);
    ce_n = 1'b1;
    wait_n(4);
  endtask

  task automatic auto_pulse();
    oe_rf_n = 1'b0;
    wait_n(2);
    oe_rf_n = 1'b1;
    wait_n(4);
  endtask

  // kind(1: 0=access, 1=auto) | row(8) | expected row(8)
  localparam logic [16:0] VEC [10] = '{
    {1'b0, 8'h5A, 8'h5A}, {1'b1, 8'h00, 8'h00}, {1'b0, 8'hFF, 8'hFF},
    {1'b1, 8'h00, 8'h01}, {1'b0, 8'h00, 8'h00}, {1'b1, 8'h00, 8'h02},
    {1'b0, 8'h80, 8'h80}, {1'b0, 8'h7F, 8'h7F}, {1'b1, 8'h00, 8'h03},
    {1'b0, 8'h01, 8'h01}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; ce_n = 1'b1; oe_rf_n = 1'b1; row_addr = '0;
    wait_n(2);
    // R9: reset state
    chk(!rfsh_valid && !self_active && !deadline_err, "R9 reset outputs",
        {rfsh_valid, self_active, deadline_err}, 0);
    do_reset();
    chk(!rfsh_valid && !deadline_err, "R9 after release", {rfsh_valid, deadline_err}, 0);

    // R1 R2 R4: vector walk
    for (int v = 0; v < 10; v++) begin
      base = ev_n;
      if (VEC[v][16]) auto_pulse();
      else            ce_cycle(VEC[v][15:8]);
      chk(ev_n - base == 1, VEC[v][16] ? "R4 one event" : "R2 one event", ev_n - base, 1);
      chk(ev_row[ev_n-1] == VEC[v][7:0], VEC[v][16] ? "R4 counter row" : "R1 R2 row",
          int'(ev_row[ev_n-1]), int'(VEC[v][7:0]));
    end

    // R4: wrap from 255 to 0 (counter is 4 now)
    base = ev_n;
    for (int k = 0; k < 253; k++) auto_pulse();
    chk(ev_n - base == 253, "R4 pulse count", ev_n - base, 253);
    chk(ev_row[ev_n-2] == 8'hFF, "R4 row before wrap", int'(ev_row[ev_n-2]), 255);
    chk(ev_row[ev_n-1] == 8'h00, "R4 wrap to zero", int'(ev_row[ev_n-1]), 0);

    // R3: refresh-pin pulses inside an access do not touch the counter
    base = ev_n;
    ce_n = 1'b0; row_addr = 8'h42;
    wait_n(1);
    oe_rf_n = 1'b0; wait_n(1); oe_rf_n = 1'b1; wait_n(1);
    oe_rf_n = 1'b0; wait_n(1); oe_rf_n = 1'b1; wait_n(1);
    ce_n = 1'b1;
    wait_n(5);
    chk(ev_n - base == 1, "R3 single event", ev_n - base, 1);
    chk(ev_row[ev_n-1] == 8'h42, "R3 access row", int'(ev_row[ev_n-1]), 'h42);
    auto_pulse();
    chk(ev_row[ev_n-1] == 8'h01, "R3 counter untouched", int'(ev_row[ev_n-1]), 1);

    // R7: request raised just before an access is held, then follows it
    do_reset();
    base = ev_n;
    oe_rf_n = 1'b0;
    wait_n(1);
    oe_rf_n = 1'b1; ce_n = 1'b0; row_addr = 8'h33;
    wait_n(5);
    chk(ev_n == base, "R7 quiet while busy", ev_n - base, 0);
    ce_n = 1'b1;
    wait_n(5);
    chk(ev_n - base == 2, "R7 two events", ev_n - base, 2);
    chk(ev_row[base] == 8'h33, "R7 access first", int'(ev_row[base]), 'h33);
    chk(ev_row[base+1] == 8'h00, "R7 counter second", int'(ev_row[base+1]), 0);
    chk(ev_cyc[base+1] - ev_cyc[base] == 1, "R7 back to back",
        ev_cyc[base+1] - ev_cyc[base], 1);

    // R5: self refresh entry cycle, walk and coverage
    do_reset();
    base = ev_n;
    oe_rf_n = 1'b0;
    wait_n(THRESH + 1);
    chk(!self_active, "R5 not yet active", self_active, 0);
    wait_n(1);
    chk(self_active, "R5 active after threshold", self_active, 1);
    wait_n(2400);
    chk(ev_n - base >= 256, "R5 rows covered", ev_n - base, 256);
    begin
      int bad = 0;
      for (int k = base; k < ev_n - 1; k++)
        if (ev_row[k+1] != ev_row[k] + 8'd1) bad++;
      chk(bad == 0 && ev_row[base] == 8'h00, "R5 consecutive walk", bad, 0);
    end
    chk(!deadline_err, "R5 no deadline error", deadline_err, 0);

    // R6: self refresh stops when the chip is selected
    ce_n = 1'b0; row_addr = 8'h10;
    wait_n(2);
    chk(!self_active, "R6 exit on select", self_active, 1'b0);
    ce_n = 1'b1; oe_rf_n = 1'b1;
    wait_n(4);

    // R8: deadline error and its stickiness
    do_reset();
    wait_n(DEADLINE - 20);
    chk(!deadline_err, "R8 before deadline", deadline_err, 0);
    wait_n(40);
    chk(deadline_err, "R8 after deadline", deadline_err, 1);
    for (int k = 0; k < 4; k++) auto_pulse();
    ce_cycle(8'h20);
    chk(deadline_err, "R8 sticky", deadline_err, 1);
    do_reset();
    chk(!deadline_err && !self_active, "R9 cleared by reset", deadline_err, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule